// File: doc/BRIEF.md
# Packed SIMD Multimedia ALU

This block is a 64-bit arithmetic unit for media code. It splits each operand into equal lanes: eight bytes, four halfwords or two words. It then runs the selected operation on every lane at the same time, and no carry or borrow passes from one lane into the next. Lane additions and subtractions can wrap, or they can clamp to the signed or unsigned limits of the lane. Compares produce lane masks that are all ones or all zeros, so later logical operations can select data without a branch. A halfword multiply and a pairwise multiply-accumulate support filter kernels. Pack narrows lanes with saturation, and unpack interleaves lanes from the two operands.

The operation is chosen by an opcode, a lane-size select, a saturation mode and a shift count, all given together with the two operands. The 64-bit result is captured in a register, so it is visible one clock after the inputs are sampled. The block holds no register file and does no instruction decoding.

Top module: `simd_media_alu`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted, and after it is released, `result` is zero until the first operation is captured.
- R2: `result` shows the outcome of the inputs sampled at the previous rising clock edge and does not change between edges. The opcode encoding is: 0 add, 1 subtract, 2 AND, 3 AND-NOT (~a & b), 4 OR, 5 XOR, 6 shift left logical, 7 shift right logical, 8 shift right arithmetic, 9 compare equal, 10 compare greater, 11 multiply, 12 multiply-add, 13 pack, 14 unpack low, 15 unpack high.
- R3: `laneSel` 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. With `satMode` 0 or 3, add and subtract wrap modulo the lane width, and no carry crosses a lane boundary.
- R4: With `satMode` 1, an add or subtract that overflows as a signed value clamps to the lane's signed maximum (0x7F..) or minimum (0x80..).
- R5: With `satMode` 2, an unsigned add that overflows gives all ones in the lane, and an unsigned subtract that would go below zero gives zero.
- R6: AND, AND-NOT (~a & b), OR and XOR act on all 64 bits, whatever the lane select.
- R7: The three shifts move each lane by `shAmt` on its own. A count equal to or larger than the lane width gives zero for the logical shifts and copies of the sign bit for the arithmetic shift.
- R8: Compare equal and compare greater (signed, a > b) fill each lane with all ones when true and all zeros when false.
- R9: Multiply always uses four signed 16-bit lanes, whatever `laneSel` is, and keeps the low 16 bits of each product.
- R10: Multiply-add multiplies the four signed 16-bit lane pairs. Products of lanes 0 and 1 are summed into result bits 31:0, and products of lanes 2 and 3 into bits 63:32, with wraparound.
- R11: Pack with `laneSel` 1 narrows 16-bit lanes to bytes, and with `laneSel` 2/3 narrows 32-bit lanes to halfwords. Narrowing is signed and saturating. The narrowed lanes of `a` fill bits 31:0 and those of `b` fill bits 63:32, keeping the lane order. With `laneSel` 0, pack gives zero.
- R12: Unpack low builds result lane 2i from `a` lane i and lane 2i+1 from `b` lane i, taking i from the lower half of the lanes. Unpack high does the same with the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Operation select |
| laneSel | input | 2 | Lane size select |
| satMode | input | 2 | Add/subtract overflow handling |
| shAmt | input | 8 | Shift count applied to every lane |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| result | output | 64 | Registered result |

## Verification
The cases hardest to reach from the ports sit on lane boundaries. Examples are a carry that would leak into the next lane, a signed clamp at the exact minimum, a pair of -32768 products whose sum reaches 2^31, and shift counts equal to the lane width. The stimulus uses hand-built operands in which neighbouring lanes hold opposite extremes, so any leak or off-by-one clamp changes a byte that is checked. Each of these operands is also run under more than one lane select.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    RS_ARITH, RS_AND, RS_ANDN, RS_OR, RS_XOR, RS_SHL, RS_SHR, RS_SRA,
    RS_EQ, RS_GT, RS_MUL, RS_MADD, RS_PACK, RS_UNPLO, RS_UNPHI, RS_ZERO
  } resSel_e;

  typedef enum logic [1:0] {SAT_WRAP, SAT_S, SAT_U} satKind_e;

  typedef struct packed {
    resSel_e  sel;
    logic     doSub;
    satKind_e sat;
  } ctlStrobes_t;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     laneA,
  input  logic [W-1:0]     laneB,
  input  logic [CNT_W-1:0] shAmt,
  input  logic             doSub,
  input  satKind_e         sat,
  output logic [W-1:0]     arithRes,
  output logic [W-1:0]     shlRes,
  output logic [W-1:0]     shrRes,
  output logic [W-1:0]     sraRes,
  output logic [W-1:0]     eqMask,
  output logic [W-1:0]     gtMask
);
  localparam int SH_W = $clog2(W);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] bEff;
  logic [W:0]   fullSum;
  logic [W-1:0] rawSum;
  logic         uOvf;
  logic         sOvf;
  logic         bigShift;
  logic [SH_W-1:0] amt;

  assign bEff    = doSub ? ~laneB : laneB;
  assign fullSum = {1'b0, laneA} + {1'b0, bEff} + {{W{1'b0}}, doSub};
  assign rawSum  = fullSum[W-1:0];
  assign uOvf    = doSub ? ~fullSum[W] : fullSum[W];
  assign sOvf    = (laneA[W-1] == bEff[W-1]) && (rawSum[W-1] != laneA[W-1]);

  always_comb begin
    unique case (sat)
      SAT_S:   arithRes = sOvf ? (laneA[W-1] ? S_MIN : S_MAX) : rawSum;
      SAT_U:   arithRes = uOvf ? (doSub ? '0 : '1) : rawSum;
      default: arithRes = rawSum;
    endcase
  end

  assign bigShift = (shAmt >= CNT_W'(W));
  assign amt      = shAmt[SH_W-1:0];
  assign shlRes   = bigShift ? '0 : (laneA << amt);
  assign shrRes   = bigShift ? '0 : (laneA >> amt);
  assign sraRes   = bigShift ? {W{laneA[W-1]}} : W'($signed(laneA) >>> amt);
  assign eqMask   = {W{laneA == laneB}};
  assign gtMask   = {W{$signed(laneA) > $signed(laneB)}};

  // Saturation guards on the lane result
  always_comb begin
    if (sat == SAT_U && !doSub)
      p_usat_add_r5: assert (arithRes >= laneA);
    if (sat == SAT_U && doSub)
      p_usat_sub_r5: assert (arithRes <= laneA);
    if (sat == SAT_S && !doSub && !laneA[W-1] && !laneB[W-1])
      p_ssat_pos_r4: assert (!arithRes[W-1]);
  end
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_alu_pkg::*;
(
  input  logic [3:0]  opcode,
  input  logic [1:0]  satMode,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes.doSub = (opcode == 4'd1);
    unique case (satMode)
      2'd1:    strobes.sat = SAT_S;
      2'd2:    strobes.sat = SAT_U;
      default: strobes.sat = SAT_WRAP;
    endcase
    unique case (opcode)
      4'd0, 4'd1: strobes.sel = RS_ARITH;
      4'd2:       strobes.sel = RS_AND;
      4'd3:       strobes.sel = RS_ANDN;
      4'd4:       strobes.sel = RS_OR;
      4'd5:       strobes.sel = RS_XOR;
      4'd6:       strobes.sel = RS_SHL;
      4'd7:       strobes.sel = RS_SHR;
      4'd8:       strobes.sel = RS_SRA;
      4'd9:       strobes.sel = RS_EQ;
      4'd10:      strobes.sel = RS_GT;
      4'd11:      strobes.sel = RS_MUL;
      4'd12:      strobes.sel = RS_MADD;
      4'd13:      strobes.sel = RS_PACK;
      4'd14:      strobes.sel = RS_UNPLO;
      default:    strobes.sel = RS_UNPHI;
    endcase
  end
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  ctlStrobes_t       strobes,
  input  logic [1:0]        laneSel,
  input  logic [CNT_W-1:0]  shAmt,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] nextResult
);
  localparam int NUM_SIZES = 3;
  localparam int MUL_LANES = DATA_W / 16;
  localparam int MADD_LANES = DATA_W / 32;
  localparam int HALF_W = DATA_W / 2;

  logic [NUM_SIZES-1:0][DATA_W-1:0] vArith, vShl, vShr, vSra, vEq, vGt, vUnpLo, vUnpHi;
  logic [1:0] sizeIdx;

  assign sizeIdx = (laneSel == 2'd3) ? 2'd2 : laneSel;

  for (genvar gw = 0; gw < NUM_SIZES; gw++) begin : g_size
    localparam int W = 8 << gw;
    localparam int N = DATA_W / W;
    for (genvar l = 0; l < N; l++) begin : g_lane
      simd_lane_unit #(.W(W), .CNT_W(CNT_W)) u_lane (
        .laneA   (opA[l*W +: W]),
        .laneB   (opB[l*W +: W]),
        .shAmt   (shAmt),
        .doSub   (strobes.doSub),
        .sat     (strobes.sat),
        .arithRes(vArith[gw][l*W +: W]),
        .shlRes  (vShl[gw][l*W +: W]),
        .shrRes  (vShr[gw][l*W +: W]),
        .sraRes  (vSra[gw][l*W +: W]),
        .eqMask  (vEq[gw][l*W +: W]),
        .gtMask  (vGt[gw][l*W +: W])
      );
    end
    for (genvar i = 0; i < N/2; i++) begin : g_unpack
      assign vUnpLo[gw][(2*i)*W +: W]   = opA[i*W +: W];
      assign vUnpLo[gw][(2*i+1)*W +: W] = opB[i*W +: W];
      assign vUnpHi[gw][(2*i)*W +: W]   = opA[(N/2+i)*W +: W];
      assign vUnpHi[gw][(2*i+1)*W +: W] = opB[(N/2+i)*W +: W];
    end
  end

  // Halfword multiply and pairwise multiply-add
  logic [MUL_LANES-1:0][31:0] prod;
  logic [DATA_W-1:0] mulRes, maddRes;
  for (genvar k = 0; k < MUL_LANES; k++) begin : g_mul
    assign prod[k] = 32'($signed(opA[k*16 +: 16]) * $signed(opB[k*16 +: 16]));
    assign mulRes[k*16 +: 16] = prod[k][15:0];
  end
  for (genvar j = 0; j < MADD_LANES; j++) begin : g_madd
    assign maddRes[j*32 +: 32] = prod[2*j] + prod[2*j+1];
  end

  // Saturating pack
  function automatic logic [7:0] clampTo8(input logic [15:0] v);
    if ($signed(v) > 16'sd127)       return 8'h7F;
    else if ($signed(v) < -16'sd128) return 8'h80;
    else                             return v[7:0];
  endfunction

  function automatic logic [15:0] clampTo16(input logic [31:0] v);
    if ($signed(v) > 32'sd32767)       return 16'h7FFF;
    else if ($signed(v) < -32'sd32768) return 16'h8000;
    else                               return v[15:0];
  endfunction

  logic [DATA_W-1:0] packHalf, packWord;
  for (genvar k = 0; k < DATA_W/16; k++) begin : g_pack16
    assign packHalf[k*8 +: 8]          = clampTo8(opA[k*16 +: 16]);
    assign packHalf[HALF_W + k*8 +: 8] = clampTo8(opB[k*16 +: 16]);
  end
  for (genvar k = 0; k < DATA_W/32; k++) begin : g_pack32
    assign packWord[k*16 +: 16]          = clampTo16(opA[k*32 +: 32]);
    assign packWord[HALF_W + k*16 +: 16] = clampTo16(opB[k*32 +: 32]);
  end

  always_comb begin
    unique case (strobes.sel)
      RS_ARITH: nextResult = vArith[sizeIdx];
      RS_AND:   nextResult = opA & opB;
      RS_ANDN:  nextResult = ~opA & opB;
      RS_OR:    nextResult = opA | opB;
      RS_XOR:   nextResult = opA ^ opB;
      RS_SHL:   nextResult = vShl[sizeIdx];
      RS_SHR:   nextResult = vShr[sizeIdx];
      RS_SRA:   nextResult = vSra[sizeIdx];
      RS_EQ:    nextResult = vEq[sizeIdx];
      RS_GT:    nextResult = vGt[sizeIdx];
      RS_MUL:   nextResult = mulRes;
      RS_MADD:  nextResult = maddRes;
      RS_PACK:  nextResult = (sizeIdx == 2'd0) ? '0 :
                             (sizeIdx == 2'd1) ? packHalf : packWord;
      RS_UNPLO: nextResult = vUnpLo[sizeIdx];
      RS_UNPHI: nextResult = vUnpHi[sizeIdx];
      default:  nextResult = '0;
    endcase
  end
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opcode,
  input  logic [1:0]        laneSel,
  input  logic [1:0]        satMode,
  input  logic [CNT_W-1:0]  shAmt,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] nextResult;

  simd_ctrl u_ctrl (
    .opcode (opcode),
    .satMode(satMode),
    .strobes(strobes)
  );

  simd_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .strobes   (strobes),
    .laneSel   (laneSel),
    .shAmt     (shAmt),
    .opA       (opA),
    .opB       (opB),
    .nextResult(nextResult)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= nextResult;
  end

  function automatic logic byteMasksOk(input logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W/8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  p_cmp_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opcode) == 4'd9 || $past(opcode) == 4'd10) && $past(laneSel) == 2'd0
      |-> byteMasksOk(result));

  p_eq_self_r8: assert property (@(posedge clk) disable iff (!rstN)
    opcode == 4'd9 && opA == opB |=> result == '1);

  p_and_r6: assert property (@(posedge clk) disable iff (!rstN)
    opcode == 4'd2 |=> result == ($past(opA) & $past(opB)));
endmodule

// File: tb/simd_media_alu_tb.sv
module simd_media_alu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  laneSel = '0;
  logic [1:0]  satMode = '0;
  logic [7:0]  shAmt = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  simd_media_alu u_dut (
    .clk(clk), .rstN(rstN), .opcode(opcode), .laneSel(laneSel),
    .satMode(satMode), .shAmt(shAmt), .opA(opA), .opB(opB), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [3:0] op, input logic [1:0] ls,
                       input logic [1:0] sm, input logic [7:0] sh,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
    @(negedge clk);
    opcode = op; laneSel = ls; satMode = sm; shAmt = sh; opA = a; opB = b;
    @(posedge clk); #1;
    check(tag, result, exp);
  endtask

  task automatic testReset();
    check("R1 in reset", result, 64'h0);
    @(negedge clk); rstN = 1'b1;
    #1 check("R1 after release", result, 64'h0);
  endtask

  task automatic testLatency();
    runOp("R2 first op", 4'd4, 2'd0, 2'd0, 8'd0, 64'h00FF, 64'hFF00, 64'hFFFF);
    @(negedge clk);
    opcode = 4'd5; opA = 64'h1; opB = 64'h3;
    #1 check("R2 held until edge", result, 64'hFFFF);
    @(posedge clk); #1;
    check("R2 updated after edge", result, 64'h2);
  endtask

  task automatic testWrap();
    runOp("R3 add8 wrap no carry", 4'd0, 2'd0, 2'd0, 8'd0, 64'hFF, 64'h01, 64'h0);
    runOp("R3 add16 carry inside lane", 4'd0, 2'd1, 2'd0, 8'd0, 64'hFF, 64'h01, 64'h100);
    runOp("R3 add32 lane on 3", 4'd0, 2'd3, 2'd3, 8'd0,
          64'h00000001_FFFFFFFF, 64'h00000001_00000001, 64'h00000002_00000000);
    runOp("R3 sub8 borrow stays", 4'd1, 2'd0, 2'd0, 8'd0, 64'h0, 64'h1, 64'hFF);
  endtask

  task automatic testSignedSat();
    runOp("R4 add8 clamp max", 4'd0, 2'd0, 2'd1, 8'd0, 64'h7F, 64'h01, 64'h7F);
    runOp("R4 sub8 clamp min", 4'd1, 2'd0, 2'd1, 8'd0, 64'h80, 64'h01, 64'h80);
    runOp("R4 add16 clamp max", 4'd0, 2'd1, 2'd1, 8'd0, 64'h7FFF, 64'h7FFF, 64'h7FFF);
    runOp("R4 add16 no ovf", 4'd0, 2'd1, 2'd1, 8'd0, 64'hFFFF, 64'h0002, 64'h0001);
  endtask

  task automatic testUnsignedSat();
    runOp("R5 add8 clamp ones", 4'd0, 2'd0, 2'd2, 8'd0, 64'h00FF, 64'h0101, 64'h01FF);
    runOp("R5 sub8 clamp zero", 4'd1, 2'd0, 2'd2, 8'd0, 64'h0500, 64'h0301, 64'h0200);
  endtask

  task automatic testLogic();
    logic [63:0] a = 64'hF0F0F0F0F0F0F0F0;
    logic [63:0] b = 64'hFF00FF00FF00FF00;
    runOp("R6 and", 4'd2, 2'd1, 2'd0, 8'd0, a, b, 64'hF000F000F000F000);
    runOp("R6 andnot", 4'd3, 2'd0, 2'd0, 8'd0, a, b, 64'h0F000F000F000F00);
    runOp("R6 or", 4'd4, 2'd2, 2'd0, 8'd0, a, b, 64'hFFF0FFF0FFF0FFF0);
    runOp("R6 xor", 4'd5, 2'd0, 2'd0, 8'd0, a, b, 64'h0FF00FF00FF00FF0);
  endtask

  task automatic testShift();
    logic [63:0] a = 64'h8001_0001_8001_0001;
    runOp("R7 sll16", 4'd6, 2'd1, 2'd0, 8'd4, a, 64'h0, 64'h0010_0010_0010_0010);
    runOp("R7 srl16", 4'd7, 2'd1, 2'd0, 8'd4, a, 64'h0, 64'h0800_0000_0800_0000);
    runOp("R7 sra16", 4'd8, 2'd1, 2'd0, 8'd4, a, 64'h0, 64'hF800_0000_F800_0000);
    runOp("R7 sra16 full count", 4'd8, 2'd1, 2'd0, 8'd16, a, 64'h0, 64'hFFFF_0000_FFFF_0000);
    runOp("R7 srl16 full count", 4'd7, 2'd1, 2'd0, 8'd16, a, 64'h0, 64'h0);
    runOp("R7 sll8 count 7", 4'd6, 2'd0, 2'd0, 8'd7, 64'h0303, 64'h0, 64'h8080);
  endtask

  task automatic testCompare();
    runOp("R8 eq8 mask", 4'd9, 2'd0, 2'd0, 8'd0,
          64'h0102030405060708, 64'h0102FF0405FF0708, 64'hFFFF00FFFF00FFFF);
    runOp("R8 gt16 signed", 4'd10, 2'd1, 2'd0, 8'd0,
          64'h0001_FFFF_8000_7FFF, 64'h0000_0000_7FFF_7FFF, 64'hFFFF_0000_0000_0000);
  endtask

  task automatic testMul();
    runOp("R9 mul low halves", 4'd11, 2'd0, 2'd0, 8'd0,
          64'h0003_FFFF_0100_1234, 64'h0004_0002_0100_0001, 64'h000C_FFFE_0000_1234);
    runOp("R10 madd pairs", 4'd12, 2'd2, 2'd0, 8'd0,
          64'h0002_0003_8000_8000, 64'h0005_0004_8000_8000, 64'h00000016_80000000);
  endtask

  task automatic testPack();
    runOp("R11 pack 16 to 8", 4'd13, 2'd1, 2'd0, 8'd0,
          64'h0100_FF00_007F_FF80, 64'h0000_0001_FFFF_0080, 64'h0001FF7F_7F807F80);
    runOp("R11 pack 32 to 16", 4'd13, 2'd2, 2'd0, 8'd0,
          64'h00010000_FFFF8000, 64'h00000005_FFFF0000, 64'h00058000_7FFF8000);
    runOp("R11 pack lane8 zero", 4'd13, 2'd0, 2'd0, 8'd0,
          64'h1234, 64'h5678, 64'h0);
  endtask

  task automatic testUnpack();
    runOp("R12 unpack low 8", 4'd14, 2'd0, 2'd0, 8'd0,
          64'h11111111_A3A2A1A0, 64'h22222222_B3B2B1B0, 64'hB3A3B2A2B1A1B0A0);
    runOp("R12 unpack high 16", 4'd15, 2'd1, 2'd0, 8'd0,
          64'hA3A3_A2A2_1111_1111, 64'hB3B3_B2B2_2222_2222, 64'hB3B3A3A3B2B2A2A2);
    runOp("R12 unpack low 32", 4'd14, 2'd2, 2'd0, 8'd0,
          64'h11111111_AAAAAAAA, 64'h22222222_BBBBBBBB, 64'hBBBBBBBB_AAAAAAAA);
  endtask

  initial begin
    #1;
    testReset();
    testLatency();
    testWrap();
    testSignedSat();
    testUnsignedSat();
    testLogic();
    testShift();
    testCompare();
    testMul();
    testPack();
    testUnpack();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule